// File: doc/BRIEF.md
# Instruction-Decoding Integer ALU

This block is a purely combinational execute stage for a fixed-width, three-operand load/store style instruction set. It receives one 32-bit instruction word together with the two register values that the surrounding pipeline has already read for it. The first value belongs to the first source field and the second to the second source field. The block decodes the register format and the immediate format itself. It returns the computed 32-bit value, the number of the register that should receive it, and a flag for encodings it does not implement.

The register file, write-back, traps on signed overflow, multiply/divide, control transfer and memory access all live outside the block. A destination of register 0 is reported as decoded. Dropping that write is left to the register file.

Top module: `isa_alu`

## Requirements
- R1: Field layout, counted from bit 31 down: op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0], with imm[15:0] for the immediate format. op = 0 selects the register format: funct picks the operation and rd is the destination. As an example, 0x00AF8020 decodes as add with rs = 5, rt = 15 and destination 16.
- R2: add (funct 0x20) returns rs_val + rt_val and sub (funct 0x22) returns rs_val − rt_val, both modulo 2^32 and with no overflow indication.
- R3: and (0x24), or (0x25) and nor (0x27) work bitwise. nor returns ~(rs_val | rt_val).
- R4: slt (funct 0x2A) returns exactly 1 when rs_val < rt_val as signed two's-complement numbers, and 0 otherwise.
- R5: sll (funct 0x00) and srl (funct 0x02) shift rt_val by the 5-bit shamt field. srl fills the vacated bits with zeros. Neither the rs field nor rs_val affects the result.
- R6: addi (op 0x08) and slti (op 0x0A) sign-extend imm. addi returns rs_val + imm, and slti returns 1/0 for a signed rs_val < imm. For every immediate-format instruction the destination is rt.
- R7: andi (op 0x0C) and ori (op 0x0D) zero-extend imm before the bitwise operation with rs_val.
- R8: lui (op 0x0F) returns imm in bits 31:16 and zeros in bits 15:0.
- R9: Any other op value, or any other funct value when op = 0, sets illegal = 1 and forces result and dest to 0. Every supported encoding gives illegal = 0.
- R10: A destination register number of 0 is reported as 0 together with the normally computed result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word to decode and execute |
| rs_val | input | 32 | Value of the register named by the rs field |
| rt_val | input | 32 | Value of the register named by the rt field |
| result | output | 32 | Computed value, 0 when illegal |
| dest | output | 5 | Destination register number, 0 when illegal |
| illegal | output | 1 | Unsupported op or funct code |

## Verification
Random legal encodings with random fields and operand values exercise every operation. Sign-mixed operands separate a signed compare from an unsigned one, and random shift amounts with nonzero rs fields show that rs plays no part in shifts. Immediates with bit 15 set separate sign extension from zero extension, so addi/slti can be told apart from andi/ori. Fully random instruction words reach the illegal space. Directed words then pin down the example encoding, wrap-around, shifts by 31, an all-zero nor and a zero destination.

// File: rtl/isa_alu_pkg.sv
package isa_alu_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  localparam int SHAMT_W = 5;
  localparam int IMM_W   = 16;

  localparam logic [OP_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OP_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OP_W-1:0] OPC_SLTI = 6'h0A;
  localparam logic [OP_W-1:0] OPC_ANDI = 6'h0C;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OP_W-1:0] OPC_LUI  = 6'h0F;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_NOR, K_SLT, K_SLL, K_SRL, K_LUI
  } alu_kind_e;

  typedef enum logic [1:0] {
    B_REG, B_SEXT, B_ZEXT
  } bsrc_e;

  typedef struct packed {
    alu_kind_e          kind;
    bsrc_e              bsrc;
    logic [REG_W-1:0]   dest;
    logic [SHAMT_W-1:0] shamt;
    logic [IMM_W-1:0]   imm;
    logic               bad;
  } dec_t;

  function automatic logic [31:0] f_sext(input logic [IMM_W-1:0] v);
    return {{(32-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [31:0] f_zext(input logic [IMM_W-1:0] v);
    return {{(32-IMM_W){1'b0}}, v};
  endfunction

  function automatic logic [31:0] f_less(input logic [31:0] a, input logic [31:0] b);
    return {31'd0, $signed(a) < $signed(b)};
  endfunction

  function automatic logic [31:0] f_upper(input logic [31:0] b);
    return b << IMM_W;
  endfunction
endpackage

// File: rtl/isa_alu_decode.sv
module isa_alu_decode
  import isa_alu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [OP_W-1:0] op;
  logic [5:0]      fn;
  logic            reg_fmt;

  assign op      = instr[31:26];
  assign fn      = instr[5:0];
  assign reg_fmt = (op == OPC_REG);

  always_comb begin
    dec.kind  = K_ADD;
    dec.bsrc  = B_REG;
    dec.dest  = reg_fmt ? instr[15:11] : instr[20:16];
    dec.shamt = instr[10:6];
    dec.imm   = instr[15:0];
    dec.bad   = 1'b0;
    case (op)
      OPC_REG: begin
        case (fn)
          FN_ADD:  dec.kind = K_ADD;
          FN_SUB:  dec.kind = K_SUB;
          FN_AND:  dec.kind = K_AND;
          FN_OR:   dec.kind = K_OR;
          FN_NOR:  dec.kind = K_NOR;
          FN_SLT:  dec.kind = K_SLT;
          FN_SLL:  dec.kind = K_SLL;
          FN_SRL:  dec.kind = K_SRL;
          default: dec.bad  = 1'b1;
        endcase
      end
      OPC_ADDI: begin dec.kind = K_ADD; dec.bsrc = B_SEXT; end
      OPC_SLTI: begin dec.kind = K_SLT; dec.bsrc = B_SEXT; end
      OPC_ANDI: begin dec.kind = K_AND; dec.bsrc = B_ZEXT; end
      OPC_ORI:  begin dec.kind = K_OR;  dec.bsrc = B_ZEXT; end
      OPC_LUI:  begin dec.kind = K_LUI; dec.bsrc = B_ZEXT; end
      default:  dec.bad = 1'b1;
    endcase
  end

  // R6: immediate-format instructions write rt
  always_comb begin
    if (!reg_fmt && !dec.bad)
      a_r6_dest_is_rt: assert (dec.dest == instr[20:16]);
  end
endmodule

// File: rtl/isa_alu_operand.sv
module isa_alu_operand
  import isa_alu_pkg::*;
(
  input  bsrc_e            bsrc,
  input  logic [IMM_W-1:0] imm,
  input  logic [31:0]      rt_val,
  output logic [31:0]      b_op
);
  always_comb begin
    case (bsrc)
      B_SEXT:  b_op = f_sext(imm);
      B_ZEXT:  b_op = f_zext(imm);
      default: b_op = rt_val;
    endcase
  end

  // R7: zero-extended operand never has upper bits set
  always_comb begin
    if (bsrc == B_ZEXT)
      a_r7_zext_upper: assert (b_op[31:IMM_W] == '0);
  end
endmodule

// File: rtl/isa_alu_exec.sv
module isa_alu_exec
  import isa_alu_pkg::*;
(
  input  alu_kind_e          kind,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [31:0]        a_op,
  input  logic [31:0]        b_op,
  output logic [31:0]        y
);
  always_comb begin
    case (kind)
      K_ADD:   y = a_op + b_op;
      K_SUB:   y = a_op - b_op;
      K_AND:   y = a_op & b_op;
      K_OR:    y = a_op | b_op;
      K_NOR:   y = ~(a_op | b_op);
      K_SLT:   y = f_less(a_op, b_op);
      K_SLL:   y = b_op << shamt;
      K_SRL:   y = b_op >> shamt;
      K_LUI:   y = f_upper(b_op);
      default: y = '0;
    endcase
  end

  always_comb begin
    // R2: difference plus subtrahend gives back the minuend
    if (kind == K_SUB) a_r2_sub_inverse: assert (y + b_op == a_op);
    // R4: compare result is a single bit
    if (kind == K_SLT) a_r4_slt_bool: assert (y[31:1] == '0);
    // R5: logical right shift never carries the top bit in
    if (kind == K_SRL && shamt != '0) a_r5_srl_fill: assert (y[31] == 1'b0);
    // R8: lui clears the low half
    if (kind == K_LUI) a_r8_lui_low: assert (y[IMM_W-1:0] == '0);
  end
endmodule

// File: rtl/isa_alu.sv
module isa_alu
  import isa_alu_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] result,
  output logic [4:0]  dest,
  output logic        illegal
);
  dec_t        dec;
  logic [31:0] b_op;
  logic [31:0] exec_y;

  isa_alu_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  isa_alu_operand u_operand (
    .bsrc   (dec.bsrc),
    .imm    (dec.imm),
    .rt_val (rt_val),
    .b_op   (b_op)
  );

  isa_alu_exec u_exec (
    .kind  (dec.kind),
    .shamt (dec.shamt),
    .a_op  (rs_val),
    .b_op  (b_op),
    .y     (exec_y)
  );

  assign illegal = dec.bad;
  assign result  = dec.bad ? '0 : exec_y;
  assign dest    = dec.bad ? '0 : dec.dest;

  // R9: unsupported encodings leave no result or destination
  always_comb begin
    if (illegal) a_r9_illegal_quiet: assert (result == '0 && dest == '0);
  end
endmodule

// File: tb/isa_alu_bench.sv
module isa_alu_bench;
  logic        clk = 1'b0;
  logic [31:0] instr = '0, rs_val = '0, rt_val = '0;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        illegal;
  int          n_checks = 0, n_errors = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  isa_alu u_isa_alu (.instr(instr), .rs_val(rs_val), .rt_val(rt_val),
                     .result(result), .dest(dest), .illegal(illegal));

  function automatic logic [31:0] r_type(input logic [4:0] s, t, d, sh, input logic [5:0] fn);
    return {6'd0, s, t, d, sh, fn};
  endfunction

  function automatic logic [31:0] i_type(input logic [5:0] op, input logic [4:0] s, t,
                                         input logic [15:0] im);
    return {op, s, t, im};
  endfunction

  // independent model written from the requirements
  task automatic model(input logic [31:0] w, a, b, output logic [31:0] r,
                       output logic [4:0] d, output logic il, output string tag);
    logic [5:0] op = w[31:26];
    logic [5:0] fn = w[5:0];
    logic [31:0] se = {{16{w[15]}}, w[15:0]};
    logic [31:0] ze = {16'h0, w[15:0]};
    int sh = int'(w[10:6]);
    il = 0; r = 0; d = (op == 0) ? w[15:11] : w[20:16]; tag = "R9";
    if (op == 0) begin
      if      (fn == 6'h20) begin r = a + b;            tag = "R2"; end
      else if (fn == 6'h22) begin r = a + ~b + 1;       tag = "R2"; end
      else if (fn == 6'h24) begin r = a & b;            tag = "R3"; end
      else if (fn == 6'h25) begin r = a | b;            tag = "R3"; end
      else if (fn == 6'h27) begin r = ~a & ~b;          tag = "R3"; end
      else if (fn == 6'h2A) begin r = (a[31] != b[31]) ? {31'd0, a[31]} : {31'd0, a < b}; tag = "R4"; end
      else if (fn == 6'h00) begin r = b; for (int i = 0; i < sh; i++) r = {r[30:0], 1'b0}; tag = "R5"; end
      else if (fn == 6'h02) begin r = b; for (int i = 0; i < sh; i++) r = {1'b0, r[31:1]}; tag = "R5"; end
      else il = 1;
    end
    else if (op == 6'h08) begin r = a + se; tag = "R6"; end
    else if (op == 6'h0A) begin r = (a[31] != se[31]) ? {31'd0, a[31]} : {31'd0, a < se}; tag = "R6"; end
    else if (op == 6'h0C) begin r = a & ze; tag = "R7"; end
    else if (op == 6'h0D) begin r = a | ze; tag = "R7"; end
    else if (op == 6'h0F) begin r = {w[15:0], 16'h0}; tag = "R8"; end
    else il = 1;
    if (il) d = 0;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic [4:0] ed, input logic ei);
    n_checks++;
    if (result !== er || dest !== ed || illegal !== ei) begin
      n_errors++;
      $display("FAIL %s: instr=%h got result=%h dest=%0d illegal=%b exp result=%h dest=%0d illegal=%b",
               tag, instr, result, dest, illegal, er, ed, ei);
    end
  endtask

  task automatic run(input logic [31:0] w, a, b, input string tag_override = "");
    logic [31:0] er; logic [4:0] ed; logic ei; string tag;
    @(negedge clk);
    instr = w; rs_val = a; rt_val = b;
    #1;
    model(w, a, b, er, ed, ei, tag);
    check(tag_override != "" ? tag_override : tag, er, ed, ei);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got hung exp finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] fns [8] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h2A, 6'h00, 6'h02};
    logic [5:0] ops [5] = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0F};
    void'($urandom(32'd4711));
    // reset-state: all-zero word is sll r0 -> 0, legal (R5)
    @(negedge clk); #1;
    check("R5 zero word", 32'h0, 5'd0, 1'b0);
    // R1 example encoding
    run(32'h00AF8020, 32'd7, 32'd9, "R1");
    // R2 wrap-around
    run(r_type(1, 2, 3, 0, 6'h20), 32'hFFFF_FFFF, 32'd1);
    run(r_type(1, 2, 3, 0, 6'h22), 32'd0, 32'd1);
    // R3 nor of zeros
    run(r_type(4, 5, 6, 0, 6'h27), 32'd0, 32'd0);
    // R4 signed compare both ways
    run(r_type(1, 2, 3, 0, 6'h2A), 32'hFFFF_FFFF, 32'd1);
    run(r_type(1, 2, 3, 0, 6'h2A), 32'd1, 32'hFFFF_FFFF);
    // R5 shifts by 31, rs field and rs_val nonzero
    run(r_type(31, 2, 3, 31, 6'h00), 32'hDEAD_BEEF, 32'h0000_0003);
    run(r_type(17, 2, 3, 31, 6'h02), 32'h1234_5678, 32'h8000_0000);
    // R6 negative immediate
    run(i_type(6'h08, 1, 9, 16'hFFFF), 32'd5, 32'hAAAA_AAAA);
    run(i_type(6'h0A, 1, 9, 16'h8000), 32'hFFFF_0000, 32'd0);
    // R7 zero extension
    run(i_type(6'h0C, 1, 9, 16'hFFFF), 32'hFFFF_FFFF, 32'd0);
    run(i_type(6'h0D, 1, 9, 16'h8000), 32'h0000_0001, 32'd0);
    // R8
    run(i_type(6'h0F, 7, 9, 16'h1234), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R9 unsupported op and funct
    run(i_type(6'h23, 1, 9, 16'h0004), 32'd1, 32'd2);
    run(r_type(1, 2, 3, 0, 6'h21), 32'd1, 32'd2);
    // R10 destination zero reported
    run(r_type(1, 2, 0, 0, 6'h20), 32'd3, 32'd4, "R10");
    run(i_type(6'h08, 1, 0, 16'h0002), 32'd3, 32'd4, "R10");
    // constrained random legal mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w;
      int k = $urandom_range(0, 12);
      if (k < 8) w = r_type($urandom, $urandom, $urandom, $urandom, fns[k]);
      else       w = i_type(ops[k-8], $urandom, $urandom, $urandom);
      run(w, $urandom, $urandom);
    end
    // fully random words reach the illegal space
    for (int n = 0; n < 1000; n++) run($urandom, $urandom, $urandom);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule